// File: doc/BRIEF.md
# Packed Odd-Width Float Element Locator

This block finds where one element of an array of 36-bit or 51-bit floating-point numbers sits in memory that is organised as 256-bit words. A 256-bit word holds seven 36-bit elements or five 51-bit elements. Finding the N-th element would normally need a division by 7 or by 5. Instead, elements are grouped into power-of-two blocks: 32 narrow elements fill 5 words with three trailing slots left empty, and 64 wide elements fill 13 words with one trailing slot left empty. Locating an element then takes a multiply by a small constant, done with shifts and adds, plus a small constant table that maps the position inside a block to a word offset and a slot.

The caller supplies a base-plus-displacement address counted in 32-bit units, an element index, an indexed/direct flag and a type select. The low three bits of the address pick a 32-bit unit inside the 256-bit word, and the upper bits are the 256-bit word address. A block always starts at the 256-bit word that holds the address.

In direct mode, the unit field is the slot, and slot values past the last real element are refused. In indexed mode, the unit field is added to the index before the sum is split into a block number and a position. The block reports the 256-bit word address, the slot and the bit offset of the element, one cycle after each request.

Top module: `sdf_elem_addr`

## Requirements
- R1: `out_valid` equals `in_valid` one clock earlier. Reset clears all outputs to zero. Cycles without a request leave `out_word`, `out_slot`, `out_bitoff` and `out_invalid` unchanged.
- R2: Direct request, narrow type (`in_wide`=0): a unit field u = `in_uaddr[2:0]` in 0..6 gives `out_word` = `in_uaddr >> 3`, `out_slot` = u and `out_invalid` = 0.
- R3: Direct request, wide type (`in_wide`=1): a unit field u in 0..4 gives `out_word` = `in_uaddr >> 3`, `out_slot` = u and `out_invalid` = 0.
- R4: Direct request with u = 7 (narrow) or u >= 5 (wide): `out_invalid` = 1, and `out_word`, `out_slot` and `out_bitoff` keep the values they had before the request.
- R5: Indexed request: s = `in_index` + u. The block number is s >> 5 (narrow) or s >> 6 (wide). The position is s mod 32 (narrow) or s mod 64 (wide).
- R6: Indexed narrow request: `out_word` = (`in_uaddr` >> 3) + 5·block + position/7, and `out_slot` = position mod 7.
- R7: Indexed wide request: `out_word` = (`in_uaddr` >> 3) + 13·block + position/5, and `out_slot` = position mod 5.
- R8: When a request is accepted, `out_bitoff` = `out_slot`·36 for narrow elements or `out_slot`·51 for wide elements, counted from bit 0 of the 256-bit word.
- R9: An indexed request never raises `out_invalid`, whatever the unit field and the index are.
- R10: `out_word` wraps modulo 2^WADDR_W when the sum overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_uaddr | input | UADDR_W (30) | Base-plus-displacement address in 32-bit units |
| in_index | input | IDX_W (24) | Element index, unsigned |
| in_indexed | input | 1 | 1 = indexed request, 0 = direct request |
| in_wide | input | 1 | 0 = 36-bit elements, 1 = 51-bit elements |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_word | output | WADDR_W (27) | 256-bit word address |
| out_slot | output | 3 | Element slot inside the word |
| out_bitoff | output | 8 | Bit offset of the element inside the word |
| out_invalid | output | 1 | Direct request named a slot that does not exist |

## Verification
The assertions assume that `in_wide`, `in_indexed` and the address inputs hold known values whenever `in_valid` is high. They also assume that every request lasts exactly one cycle, so each result belongs to a single request. The bench changes inputs only at falling edges and starts from defined values. It mixes back-to-back requests with idle gaps, so the hold behaviour is exercised. Indices near the top of their range and addresses near the top of the word space are included, so the wrap stays inside defined modulo arithmetic and the check still works.

// File: rtl/sdfa_pkg.sv
package sdfa_pkg;
  localparam int unsigned NARROW_BITS   = 36;
  localparam int unsigned WIDE_BITS     = 51;
  localparam int unsigned NARROW_PER_WD = 7;
  localparam int unsigned WIDE_PER_WD   = 5;
  localparam int unsigned NARROW_POS_W  = 5;
  localparam int unsigned WIDE_POS_W    = 6;
  localparam int unsigned NARROW_BLK_WD = 5;
  localparam int unsigned WIDE_BLK_WD   = 13;
  localparam int unsigned WOFF_W        = 4;
  localparam int unsigned UNIT_SEL_W    = 3;

  typedef enum logic {ELEM_NARROW = 1'b0, ELEM_WIDE = 1'b1} elem_kind_e;

  function automatic logic [2:0] last_slot(input logic wide);
    return wide ? 3'(WIDE_PER_WD - 1) : 3'(NARROW_PER_WD - 1);
  endfunction

  function automatic logic [7:0] slot_to_bits(input logic [2:0] slot, input logic wide);
    logic [7:0] s8;
    s8 = {5'd0, slot};
    return wide ? (s8 << 5) + (s8 << 4) + (s8 << 1) + s8
                : (s8 << 5) + (s8 << 2);
  endfunction
endpackage

// File: rtl/sdf_slot_lut.sv
module sdf_slot_lut #(
  parameter int unsigned PER_WORD = 7,
  parameter int unsigned POS_W    = 5,
  parameter int unsigned WOFF_W   = 4
) (
  input  logic [POS_W-1:0]  pos_i,
  output logic [WOFF_W-1:0] woff_o,
  output logic [2:0]        slot_o
);
  localparam int unsigned ENTRIES  = 1 << POS_W;
  localparam int unsigned LAST_OFF = (ENTRIES - 1) / PER_WORD;

  logic [WOFF_W-1:0] woff_tab [ENTRIES];
  logic [2:0]        slot_tab [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    assign woff_tab[e] = WOFF_W'(e / PER_WORD);
    assign slot_tab[e] = 3'(e % PER_WORD);
  end

  assign woff_o = woff_tab[pos_i];
  assign slot_o = slot_tab[pos_i];

  always_comb begin
    AST_LUT_SLOT_IN_WORD: assert (slot_o < 3'(PER_WORD)) else $error("slot beyond word"); // R6
    AST_LUT_OFF_IN_BLOCK: assert (woff_o <= WOFF_W'(LAST_OFF)) else $error("offset beyond block"); // R7
  end
endmodule

// File: rtl/sdf_block_scale.sv
module sdf_block_scale #(
  parameter int unsigned BLK_LEN = 5,
  parameter int unsigned IN_W    = 20,
  parameter int unsigned OUT_W   = 27
) (
  input  logic [IN_W-1:0]  blk_i,
  output logic [OUT_W-1:0] words_o
);
  localparam int unsigned TERMS = $clog2(BLK_LEN + 1);

  logic [OUT_W-1:0] ext;
  logic [OUT_W-1:0] part [TERMS];

  assign ext = OUT_W'(blk_i);

  for (genvar b = 0; b < TERMS; b++) begin : g_term
    if (((BLK_LEN >> b) & 1) != 0) begin : g_on
      assign part[b] = ext << b;
    end else begin : g_off
      assign part[b] = '0;
    end
  end

  always_comb begin
    words_o = '0;
    for (int b = 0; b < TERMS; b++) words_o = words_o + part[b];
  end
endmodule

// File: rtl/sdf_elem_addr.sv
module sdf_elem_addr
  import sdfa_pkg::*;
#(
  parameter int unsigned UADDR_W = 30,
  parameter int unsigned IDX_W   = 24,
  localparam int unsigned WADDR_W = UADDR_W - UNIT_SEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [UADDR_W-1:0] in_uaddr,
  input  logic [IDX_W-1:0]   in_index,
  input  logic               in_indexed,
  input  logic               in_wide,
  output logic               out_valid,
  output logic [WADDR_W-1:0] out_word,
  output logic [2:0]         out_slot,
  output logic [7:0]         out_bitoff,
  output logic               out_invalid
);
  localparam int unsigned SUM_W  = IDX_W + 1;
  localparam int unsigned NBLK_W = SUM_W - NARROW_POS_W;
  localparam int unsigned WBLK_W = SUM_W - WIDE_POS_W;

  logic [WADDR_W-1:0]    base_word;
  logic [UNIT_SEL_W-1:0] unit_sel;
  logic [SUM_W-1:0]      elem_sum;

  assign base_word = in_uaddr[UADDR_W-1:UNIT_SEL_W];
  assign unit_sel  = in_uaddr[UNIT_SEL_W-1:0];
  assign elem_sum  = SUM_W'(in_index) + SUM_W'(unit_sel);

  // narrow path: 32 elements over 5 words
  logic [WOFF_W-1:0]  n_woff;
  logic [2:0]         n_slot;
  logic [WADDR_W-1:0] n_blk_words;

  sdf_slot_lut #(.PER_WORD(NARROW_PER_WD), .POS_W(NARROW_POS_W), .WOFF_W(WOFF_W)) u_lut_n (
    .pos_i (elem_sum[NARROW_POS_W-1:0]),
    .woff_o(n_woff),
    .slot_o(n_slot)
  );

  sdf_block_scale #(.BLK_LEN(NARROW_BLK_WD), .IN_W(NBLK_W), .OUT_W(WADDR_W)) u_scale_n (
    .blk_i  (elem_sum[SUM_W-1:NARROW_POS_W]),
    .words_o(n_blk_words)
  );

  // wide path: 64 elements over 13 words
  logic [WOFF_W-1:0]  w_woff;
  logic [2:0]         w_slot;
  logic [WADDR_W-1:0] w_blk_words;

  sdf_slot_lut #(.PER_WORD(WIDE_PER_WD), .POS_W(WIDE_POS_W), .WOFF_W(WOFF_W)) u_lut_w (
    .pos_i (elem_sum[WIDE_POS_W-1:0]),
    .woff_o(w_woff),
    .slot_o(w_slot)
  );

  sdf_block_scale #(.BLK_LEN(WIDE_BLK_WD), .IN_W(WBLK_W), .OUT_W(WADDR_W)) u_scale_w (
    .blk_i  (elem_sum[SUM_W-1:WIDE_POS_W]),
    .words_o(w_blk_words)
  );

  // selection between direct and indexed forms
  logic               direct_illegal;
  logic [WADDR_W-1:0] idx_word;
  logic [2:0]         idx_slot;
  logic [WADDR_W-1:0] next_word;
  logic [2:0]         next_slot;

  assign direct_illegal = !in_indexed && (unit_sel > last_slot(in_wide));

  always_comb begin
    if (in_wide == ELEM_WIDE) begin
      idx_word = base_word + w_blk_words + WADDR_W'(w_woff);
      idx_slot = w_slot;
    end else begin
      idx_word = base_word + n_blk_words + WADDR_W'(n_woff);
      idx_slot = n_slot;
    end
    next_word = in_indexed ? idx_word : base_word;
    next_slot = in_indexed ? idx_slot : unit_sel;
  end

  logic r_wide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_word    <= '0;
      out_slot    <= '0;
      out_bitoff  <= '0;
      out_invalid <= 1'b0;
      r_wide      <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        r_wide      <= in_wide;
        out_invalid <= direct_illegal;
        if (!direct_illegal) begin
          out_word   <= next_word;
          out_slot   <= next_slot;
          out_bitoff <= slot_to_bits(next_slot, in_wide);
        end
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R1
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_word) && $stable(out_slot) && $stable(out_invalid)); // R1
  AST_NARROW_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_invalid && !r_wide |-> out_slot <= 3'd6); // R2
  AST_WIDE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_invalid && r_wide |-> out_slot <= 3'd4); // R3
  AST_ILLEGAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_invalid |-> $stable(out_word) && $stable(out_slot) && $stable(out_bitoff)); // R4
  AST_INDEXED_NEVER_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_indexed |=> !out_invalid); // R9
  AST_BITOFF_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_invalid |-> out_bitoff <= 8'd216); // R8
endmodule

// File: tb/sdf_elem_addr_bench.sv
module sdf_elem_addr_bench;
  localparam int UADDR_W = 30;
  localparam int IDX_W   = 24;
  localparam int WADDR_W = UADDR_W - 3;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic [UADDR_W-1:0] in_uaddr = '0;
  logic [IDX_W-1:0]   in_index = '0;
  logic               in_indexed = 1'b0;
  logic               in_wide = 1'b0;
  logic               out_valid;
  logic [WADDR_W-1:0] out_word;
  logic [2:0]         out_slot;
  logic [7:0]         out_bitoff;
  logic               out_invalid;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sdf_elem_addr #(.UADDR_W(UADDR_W), .IDX_W(IDX_W)) u_sdf_elem_addr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_uaddr(in_uaddr),
    .in_index(in_index), .in_indexed(in_indexed), .in_wide(in_wide),
    .out_valid(out_valid), .out_word(out_word), .out_slot(out_slot),
    .out_bitoff(out_bitoff), .out_invalid(out_invalid)
  );

  // reference model
  longint exp_word = 0;
  int     exp_slot = 0, exp_bits = 0;
  bit     exp_valid = 0, exp_invalid = 0;
  string  tag_pos = "R1", tag_bad = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_valid = 0; exp_word = 0; exp_slot = 0; exp_bits = 0; exp_invalid = 0;
      tag_pos = "R1"; tag_bad = "R1";
    end else begin
      exp_valid = in_valid;
      if (in_valid) begin
        longint wa, s, blk, pos, per, bl, bw;
        int sub;
        wa  = longint'(in_uaddr) / 8;
        sub = int'(in_uaddr) % 8;
        per = in_wide ? 5 : 7;
        if (!in_indexed) begin
          tag_bad = "R4";
          if (sub >= per) exp_invalid = 1;
          else begin
            exp_invalid = 0;
            exp_word = wa; exp_slot = sub;
            exp_bits = sub * (in_wide ? 51 : 36);
            tag_pos = in_wide ? "R3" : "R2";
          end
        end else begin
          // R5: sum, then block and position
          bl = in_wide ? 64 : 32;
          bw = in_wide ? 13 : 5;
          s = longint'(in_index) + sub;
          blk = s / bl; pos = s % bl;
          exp_invalid = 0;
          tag_bad = "R9";
          exp_word = (wa + blk * bw + pos / per) % (longint'(1) << WADDR_W); // R10
          exp_slot = int'(pos % per);
          exp_bits = exp_slot * (in_wide ? 51 : 36);
          tag_pos = in_wide ? "R7" : "R6";
        end
      end
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R1 valid", out_valid, exp_valid);
      check({tag_pos, " word"}, out_word, exp_word);
      check({tag_pos, " slot"}, out_slot, exp_slot);
      check("R8 bitoff", out_bitoff, exp_bits);
      check({tag_bad, " invalid"}, out_invalid, exp_invalid);
    end
  end

  task automatic req(input logic [UADDR_W-1:0] a, input logic [IDX_W-1:0] i,
                     input bit idx, input bit wide);
    @(negedge clk);
    in_valid = 1; in_uaddr = a; in_index = i; in_indexed = idx; in_wide = wide;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 0; in_uaddr = '1; in_index = '1; in_indexed = 0; in_wide = 1;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_checks++; n_errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 reset valid", out_valid, 0);
    check("R1 reset word", out_word, 0);
    check("R1 reset invalid", out_invalid, 0);
    rst_n = 1;
    // R2 narrow direct, including illegal unit 7 (R4)
    for (int u = 0; u < 8; u++) req(30'h1234_5670 | 30'(u), 0, 0, 0);
    idle(2);
    // R3 wide direct, units 5..7 illegal (R4)
    for (int u = 0; u < 8; u++) req(30'h0ABC_DE00 | 30'(u), 0, 0, 1);
    idle(1);
    req(30'h0000_0043, 0, 0, 0);
    req(30'h0000_0047, 0, 0, 0);  // R4 hold after legal
    idle(2);
    // R6 narrow indexed edges, R9 with unit 7
    req(30'h0000_0107, 0, 1, 0);
    req(30'h0000_0107, 24, 1, 0);
    req(30'h0000_0107, 25, 1, 0);
    req(30'h0000_0100, 31, 1, 0);
    req(30'h0000_0100, 32, 1, 0);
    req(30'h0000_0100, 100, 1, 0);
    // R7 wide indexed edges
    req(30'h0000_0205, 58, 1, 1);
    req(30'h0000_0200, 63, 1, 1);
    req(30'h0000_0200, 64, 1, 1);
    req(30'h0000_0207, 1000, 1, 1);
    // R10 wrap
    req('1, '1, 1, 0);
    req('1, '1, 1, 1);
    req(30'h3FFF_FFF8, 24'h00_0040, 1, 1);
    idle(3);
    for (int n = 0; n < 3000; n++) begin
      if (($urandom % 5) == 0) idle(1 + $urandom % 3);
      req(30'($urandom), (($urandom % 2) == 0) ? 24'($urandom % 300) : 24'($urandom),
          1'($urandom), 1'($urandom));
    end
    idle(3);
    finish_run();
  end
endmodule